// File: doc/BRIEF.md
# Slow-Domain Register Access Bridge

This block lets a bus master on a fast clock read and write one register that lives on a slow peripheral clock. The two clocks are unrelated, and the peripheral clock may be thousands of times slower than the bus clock. Each transfer is carried across as a toggle request. The request crosses a multi-flop synchronizer into the peripheral domain. That domain performs the write or captures the register, then toggles an acknowledge. The acknowledge returns through a second synchronizer to the bus domain.

Multi-bit data never passes through a synchronizer. Write data sits in a bus-domain holding register, and read data sits in a peripheral-domain capture register. Each of these registers stays unchanged while the toggle pair is in flight.

The `post_mode` input selects how the bus sees a transfer:
- **Stalling:** the access holds ready low until the acknowledge has come back.
- **Posted:** the access finishes at once. Software later polls a busy bit, or waits for a sticky sync-done interrupt, and then collects the captured value with no wait states.

The `hold_on_busy` input decides what happens to a new transfer that arrives while one is still in flight. It either waits or is dropped.

Top module: `slowreg_bridge`

## Requirements
- R1: After reset, the status word reads 0, `irq` is low, and the capture register reads 0.
- R2: In stalling mode, a write to the value register (byte offset 0x0) holds `pready` low until the transfer completes. The peripheral then sees the written data on `per_wdata` while `per_we` is high.
- R3: In stalling mode, a read of the value register (0x0) launches a capture and holds `pready` low until the transfer completes. It returns the `per_rdval` that was present at capture time.
- R4: For a stalled access with request synchronizer depth S (default 3), the stall is timed from the bus edge that launches the request to the bus edge that ends the access. It is longer than (S+1) peripheral periods plus 2 bus periods, and no longer than (S+2) peripheral periods plus 3 bus periods.
- R5: In posted mode, the following accesses complete with no wait state when the bridge is idle:
  - a write to 0x0;
  - a write to the command register (0x4) with bit 0 set, which launches a capture.

  After either one, status bit 0 (busy, at 0x8) reads 1 until the acknowledge returns, then 0.
- R6: In posted mode, a read of 0x0 completes with no wait state. It returns the last captured value and launches no transfer, so busy stays 0.
- R7: Status bit 1 (sync-done flag) is set when a posted transfer completes and not when a stalled one completes. `irq` equals the flag ANDed with status bit 2 (interrupt enable).
- R8: A status write with bit 1 set clears the flag. A status write with bit 1 clear leaves it unchanged. Every status write loads the enable from bit 2.
- R9: With `hold_on_busy`=1, a launching access made while busy waits until the earlier transfer completes and is then launched. The peripheral receives both writes, in order.
- R10: With `hold_on_busy`=0, a launching access made while busy completes with no wait state and has no effect: no peripheral write, and the capture is unchanged.
- R11: Status reads and status writes never insert wait states.
- R12: Each write request produces exactly one single-cycle `per_we` pulse in the peripheral domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bus clock |
| brst | input | 1 | Bus-domain synchronous reset, active high |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write |
| paddr | input | AW | Byte address: 0x0 value, 0x4 command, 0x8 status |
| pwdata | input | DW | Write data |
| prdata | output | DW | Read data |
| pready | output | 1 | Ready; low inserts wait states |
| post_mode | input | 1 | 1 = posted, 0 = stalling |
| hold_on_busy | input | 1 | 1 = stall requests made while busy, 0 = drop them |
| irq | output | 1 | Sync-done interrupt |
| pclk | input | 1 | Peripheral clock, asynchronous |
| prst | input | 1 | Peripheral-domain synchronous reset, active high |
| per_rdval | input | DW | Current peripheral register value |
| per_we | output | 1 | Peripheral write strobe (pclk domain) |
| per_wdata | output | DW | Peripheral write data, stable during a transfer |

## Verification
The hardest state to reach is a second request that lands while a posted transfer is still crossing. To reach it, the bench launches a posted write with a slow peripheral clock and then issues the next access in the following bus cycles. The slow clock keeps the acknowledge far away during those cycles. The bench checks both outcomes through the peripheral write log and a posted readback of the capture register: with holding enabled the second write waits and then lands, and with holding disabled it vanishes. The latency bounds are checked at four unrelated clock ratios, one of them with the peripheral clock faster than the bus clock.

// File: rtl/slowreg_pkg.sv
`timescale 1ns/1ps
package slowreg_pkg;
    localparam int OFF_VAL  = 0;
    localparam int OFF_CMD  = 4;
    localparam int OFF_STAT = 8;

    localparam int ST_BUSY = 0;
    localparam int ST_FLAG = 1;
    localparam int ST_IEN  = 2;

    typedef enum logic [1:0] {SEL_VAL, SEL_CMD, SEL_STAT, SEL_NONE} regsel_e;
    typedef enum logic [1:0] {BD_PASS, BD_LAUNCH, BD_WAIT, BD_DROP} bus_dec_e;

    typedef struct packed {
        logic ien;
        logic flag;
        logic busy;
    } stat_t;

    function automatic regsel_e decode_sel(input int unsigned off);
        if (off == OFF_VAL)       return SEL_VAL;
        else if (off == OFF_CMD)  return SEL_CMD;
        else if (off == OFF_STAT) return SEL_STAT;
        else                      return SEL_NONE;
    endfunction

    function automatic logic wants_xfer(input regsel_e sel, input logic wr,
                                        input logic cmd_go, input logic posted);
        case (sel)
            SEL_VAL: return wr | ~posted;
            SEL_CMD: return wr & cmd_go;
            default: return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/sr_sync_chain.sv
`timescale 1ns/1ps
module sr_sync_chain #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] st;

    always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st <= {st[STAGES-2:0], d};
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/sr_periph_side.sv
`timescale 1ns/1ps
module sr_periph_side #(
    parameter int DW         = 32,
    parameter int REQ_STAGES = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_tgl,
    input  logic          req_wr,
    input  logic [DW-1:0] per_rdval,
    output logic [DW-1:0] cap,
    output logic          ack_tgl,
    output logic          per_we
);
    logic req_s, seen_q, pend_q, ack_q, we_q, evt;
    logic [DW-1:0] cap_q;

    sr_sync_chain #(.STAGES(REQ_STAGES)) u_req_sync (
        .clk(clk), .rst(rst), .d(req_tgl), .q(req_s)
    );

    assign evt = req_s ^ seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= 1'b0;
            pend_q <= 1'b0;
            ack_q  <= 1'b0;
            we_q   <= 1'b0;
            cap_q  <= '0;
        end else begin
            we_q   <= 1'b0;
            pend_q <= evt;
            if (evt) begin
                seen_q <= req_s;
                if (req_wr) we_q  <= 1'b1;
                else        cap_q <= per_rdval;
            end
            if (pend_q) ack_q <= ~ack_q;
        end
    end

    assign cap     = cap_q;
    assign ack_tgl = ack_q;
    assign per_we  = we_q;

    // R12: strobe lasts one peripheral cycle
    a_r12_single_pulse: assert property (@(posedge clk) disable iff (rst)
        we_q |=> !we_q);
    // R12: acknowledge only moves one cycle after an action
    a_r12_ack_after_action: assert property (@(posedge clk) disable iff (rst)
        (ack_q != $past(ack_q)) |-> $past(pend_q));
endmodule

// File: rtl/sr_bus_side.sv
`timescale 1ns/1ps
module sr_bus_side
    import slowreg_pkg::*;
#(
    parameter int DW         = 32,
    parameter int AW         = 4,
    parameter int ACK_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          psel,
    input  logic          penable,
    input  logic          pwrite,
    input  logic [AW-1:0] paddr,
    input  logic [DW-1:0] pwdata,
    output logic [DW-1:0] prdata,
    output logic          pready,
    input  logic          post_mode,
    input  logic          hold_on_busy,
    output logic          irq,
    input  logic [DW-1:0] cap,
    input  logic          ack_tgl,
    output logic          req_tgl,
    output logic          req_wr,
    output logic [DW-1:0] wdata
);
    logic req_q, wr_q, busy_q, mine_q, post_q, flag_q, ien_q, seen_q;
    logic [DW-1:0] hold_q;
    logic ack_s, ack_evt, acc, want, launch, stat_wr;
    regsel_e  sel;
    bus_dec_e dec;
    stat_t    stat;

    sr_sync_chain #(.STAGES(ACK_STAGES)) u_ack_sync (
        .clk(clk), .rst(rst), .d(ack_tgl), .q(ack_s)
    );

    always_comb begin
        acc     = psel & penable;
        sel     = decode_sel(int'(paddr));
        want    = acc & wants_xfer(sel, pwrite, pwdata[0], post_mode);
        ack_evt = ack_s ^ seen_q;
        stat_wr = acc & pwrite & (sel == SEL_STAT);
        if (!want)       dec = BD_PASS;
        else if (mine_q) dec = BD_WAIT;
        else if (busy_q) dec = hold_on_busy ? BD_WAIT : BD_DROP;
        else             dec = BD_LAUNCH;
        launch = (dec == BD_LAUNCH);
        case (dec)
            BD_LAUNCH: pready = post_mode;
            BD_WAIT:   pready = mine_q & ack_evt;
            default:   pready = 1'b1;
        endcase
        stat = '{ien: ien_q, flag: flag_q, busy: busy_q};
        prdata = (sel == SEL_STAT) ? {{(DW-3){1'b0}}, stat} : cap;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= 1'b0;
            wr_q   <= 1'b0;
            busy_q <= 1'b0;
            mine_q <= 1'b0;
            post_q <= 1'b0;
            flag_q <= 1'b0;
            ien_q  <= 1'b0;
            seen_q <= 1'b0;
            hold_q <= '0;
        end else begin
            if (launch) begin
                req_q  <= ~req_q;
                wr_q   <= pwrite & (sel == SEL_VAL);
                busy_q <= 1'b1;
                mine_q <= ~post_mode;
                post_q <= post_mode;
                if (pwrite && sel == SEL_VAL) hold_q <= pwdata;
            end
            if (ack_evt) begin
                seen_q <= ack_s;
                busy_q <= 1'b0;
                mine_q <= 1'b0;
            end
            if (ack_evt && post_q)                 flag_q <= 1'b1;
            else if (stat_wr && pwdata[ST_FLAG])   flag_q <= 1'b0;
            if (stat_wr) ien_q <= pwdata[ST_IEN];
        end
    end

    assign irq     = flag_q & ien_q;
    assign req_tgl = req_q;
    assign req_wr  = wr_q;
    assign wdata   = hold_q;

    // R11: wait states only on value or command accesses
    a_r11_wait_only_xfer: assert property (@(posedge clk) disable iff (rst)
        (psel && penable && !pready) |-> (sel == SEL_VAL || sel == SEL_CMD));
    // R5: a launch makes the bridge busy
    a_r5_busy_after_launch: assert property (@(posedge clk) disable iff (rst)
        launch |=> busy_q);
    // R10: request line frozen while a transfer is in flight
    a_r10_no_relaunch: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !ack_evt) |=> (req_q == $past(req_q)));
    // R7: flag only rises after a posted completion
    a_r7_flag_on_posted_done: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(ack_evt && post_q));
    // R4: acknowledge never arrives unrequested
    a_r4_ack_only_busy: assert property (@(posedge clk) disable iff (rst)
        ack_evt |-> busy_q);
endmodule

// File: rtl/slowreg_bridge.sv
`timescale 1ns/1ps
module slowreg_bridge #(
    parameter int DW         = 32,
    parameter int AW         = 4,
    parameter int REQ_STAGES = 3,
    parameter int ACK_STAGES = 2
) (
    input  logic          bclk,
    input  logic          brst,
    input  logic          psel,
    input  logic          penable,
    input  logic          pwrite,
    input  logic [AW-1:0] paddr,
    input  logic [DW-1:0] pwdata,
    output logic [DW-1:0] prdata,
    output logic          pready,
    input  logic          post_mode,
    input  logic          hold_on_busy,
    output logic          irq,
    input  logic          pclk,
    input  logic          prst,
    input  logic [DW-1:0] per_rdval,
    output logic          per_we,
    output logic [DW-1:0] per_wdata
);
    logic          req_tgl, req_wr, ack_tgl;
    logic [DW-1:0] cap, wdata;

    sr_bus_side #(.DW(DW), .AW(AW), .ACK_STAGES(ACK_STAGES)) u_bus (
        .clk(bclk), .rst(brst), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .post_mode(post_mode), .hold_on_busy(hold_on_busy),
        .irq(irq), .cap(cap), .ack_tgl(ack_tgl), .req_tgl(req_tgl),
        .req_wr(req_wr), .wdata(wdata)
    );

    sr_periph_side #(.DW(DW), .REQ_STAGES(REQ_STAGES)) u_per (
        .clk(pclk), .rst(prst), .req_tgl(req_tgl), .req_wr(req_wr),
        .per_rdval(per_rdval), .cap(cap), .ack_tgl(ack_tgl), .per_we(per_we)
    );

    assign per_wdata = wdata;
endmodule

// File: tb/slowreg_bridge_tb.sv
`timescale 1ns/1ps
module slowreg_bridge_tb;
    localparam int DW = 32, AW = 4, S = 3, TB = 10;
    localparam logic [AW-1:0] A_VAL = 4'h0, A_CMD = 4'h4, A_STAT = 4'h8;

    logic bclk = 0, pclk = 0, brst = 1, prst = 1;
    logic psel = 0, penable = 0, pwrite = 0, post_mode = 0, hold_on_busy = 1;
    logic [AW-1:0] paddr = '0;
    logic [DW-1:0] pwdata = '0, per_rdval = '0;
    logic [DW-1:0] prdata, per_wdata;
    logic pready, irq, per_we;

    int total = 0, bad = 0, phalf = 37, wcnt = 0;
    logic [DW-1:0] wlog [32];
    logic [DW-1:0] exp_cap = '0;

    slowreg_bridge u_dut (
        .bclk(bclk), .brst(brst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .post_mode(post_mode), .hold_on_busy(hold_on_busy), .irq(irq),
        .pclk(pclk), .prst(prst), .per_rdval(per_rdval), .per_we(per_we),
        .per_wdata(per_wdata)
    );

    always #5 bclk = ~bclk;
    initial forever #(phalf) pclk = ~pclk;

    always @(negedge pclk) if (!prst && per_we) begin
        if (wcnt < 32) wlog[wcnt] = per_wdata;
        wcnt++;
    end

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic apb(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       output logic [DW-1:0] rd, output int w);
        @(posedge bclk); #1;
        psel = 1; penable = 0; pwrite = wr; paddr = a; pwdata = d;
        @(posedge bclk); #1;
        penable = 1; w = 0;
        @(negedge bclk);
        while (!pready && w < 100000) begin w++; @(negedge bclk); end
        rd = prdata;
        @(posedge bclk); #1;
        psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic chk_lat(input int w, input string tag);
        int lo = (S + 1) * 2 * phalf + TB;  // one bus period of slack below the bound
        int hi = (S + 2) * 2 * phalf + 3 * TB;
        chk(w * TB >= lo && w * TB <= hi, tag, w * TB, hi);
    endtask

    task automatic wait_idle();
        logic [DW-1:0] rd; int w;
        for (int i = 0; i < 400; i++) begin
            apb(0, A_STAT, 0, rd, w);
            if (!rd[0]) break;
        end
    endtask

    task automatic t_reset();
        logic [DW-1:0] rd; int w;
        @(negedge bclk);
        chk(irq == 0, "R1 irq after reset", irq, 0);
        apb(0, A_STAT, 0, rd, w);
        chk(rd == 0, "R1 status after reset", rd, 0);
        chk(w == 0, "R11 status read waits", w, 0);
        post_mode = 1;
        apb(0, A_VAL, 0, rd, w);
        chk(rd == 0 && w == 0, "R1 R6 capture after reset", rd, 0);
        post_mode = 0;
    endtask

    task automatic t_stall(input int half);
        logic [DW-1:0] rd, v; int w, n;
        phalf = half;
        repeat (4) @(posedge pclk);
        post_mode = 0; hold_on_busy = 1;
        v = $urandom; n = wcnt;
        apb(1, A_VAL, v, rd, w);
        chk_lat(w, "R4 stalled write latency");
        repeat (3) @(negedge pclk);
        chk(wcnt == n + 1, "R12 one strobe per write", wcnt, n + 1);
        chk(wlog[n] == v, "R2 stalled write data", wlog[n], v);
        v = $urandom; per_rdval = v;
        apb(0, A_VAL, 0, rd, w);
        exp_cap = v;
        chk_lat(w, "R4 stalled read latency");
        chk(rd == v, "R3 stalled read data", rd, v);
    endtask

    task automatic t_posted();
        logic [DW-1:0] rd, v; int w;
        phalf = 37; repeat (4) @(posedge pclk);
        post_mode = 0;
        apb(1, A_STAT, 32'h6, rd, w);
        chk(w == 0, "R11 status write waits", w, 0);
        apb(0, A_VAL, 0, rd, w);            // stalled read, must not set flag
        apb(0, A_STAT, 0, rd, w);
        chk(rd[1] == 0, "R7 no flag after stalled transfer", rd[1], 0);
        post_mode = 1;
        v = $urandom; per_rdval = v;
        apb(1, A_CMD, 32'h1, rd, w);
        chk(w == 0, "R5 posted command waits", w, 0);
        apb(0, A_STAT, 0, rd, w);
        chk(rd[0] == 1, "R5 busy while crossing", rd[0], 1);
        wait_idle();
        exp_cap = v;
        @(negedge bclk);
        chk(irq == 1, "R7 irq after posted done", irq, 1);
        per_rdval = ~v;
        apb(0, A_VAL, 0, rd, w);
        chk(rd == v && w == 0, "R6 posted read of capture", rd, v);
        apb(0, A_STAT, 0, rd, w);
        chk(rd == 32'h6, "R6 R7 no launch, flag and enable set", rd, 32'h6);
        apb(1, A_STAT, 32'h4, rd, w);
        apb(0, A_STAT, 0, rd, w);
        chk(rd[1] == 1, "R8 writing 0 keeps flag", rd[1], 1);
        apb(1, A_STAT, 32'h2, rd, w);
        apb(0, A_STAT, 0, rd, w);
        chk(rd == 0, "R8 write 1 clears flag, enable off", rd, 0);
        apb(1, A_CMD, 32'h1, rd, w);
        wait_idle();
        @(negedge bclk);
        chk(irq == 0, "R7 masked irq", irq, 0);
        apb(1, A_STAT, 32'h4, rd, w);
        @(negedge bclk);
        chk(irq == 1, "R7 enable exposes pending flag", irq, 1);
        per_rdval = v;  // value at that capture was ~v
        exp_cap = ~v;
        apb(1, A_STAT, 32'h2, rd, w);
    endtask

    task automatic t_drop();
        logic [DW-1:0] rd, a, b; int w, n;
        post_mode = 1; hold_on_busy = 0;
        a = $urandom; b = ~a; n = wcnt;
        per_rdval = 32'h1234_5678;
        apb(1, A_VAL, a, rd, w);
        apb(1, A_CMD, 32'h1, rd, w);
        chk(w == 0, "R10 dropped command waits", w, 0);
        apb(1, A_VAL, b, rd, w);
        chk(w == 0, "R10 dropped write waits", w, 0);
        wait_idle();
        repeat (3) @(negedge pclk);
        chk(wcnt == n + 1, "R10 only first write reaches peripheral", wcnt, n + 1);
        chk(wlog[n] == a, "R10 first write data", wlog[n], a);
        apb(0, A_VAL, 0, rd, w);
        chk(rd == exp_cap, "R10 capture unchanged", rd, exp_cap);
    endtask

    task automatic t_hold();
        logic [DW-1:0] rd, a, b; int w, n;
        post_mode = 1; hold_on_busy = 1;
        a = $urandom; b = $urandom; n = wcnt;
        apb(1, A_VAL, a, rd, w);
        chk(w == 0, "R5 posted write waits", w, 0);
        apb(1, A_VAL, b, rd, w);
        chk(w > 0, "R9 second write held while busy", w, 1);
        wait_idle();
        repeat (3) @(negedge pclk);
        chk(wcnt == n + 2, "R9 both writes delivered", wcnt, n + 2);
        chk(wlog[n] == a && wlog[n + 1] == b, "R9 write order", wlog[n + 1], b);
    endtask

    initial begin
        #1_500_000;
        total++; bad++;
        $display("FAIL watchdog expired act=0 exp=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #300;
        @(posedge bclk); #1 brst = 0;
        @(posedge pclk); #1 prst = 0;
        t_reset();
        t_stall(3);
        t_stall(7);
        t_stall(23);
        t_stall(37);
        t_posted();
        t_drop();
        t_hold();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule